// File: doc/BRIEF.md
# Host I/O Window Decoder with Legacy Alias Folding

This block decides whether a host-side I/O transaction falls into one of two programmable I/O windows and should therefore be claimed and sent downstream. A small decode-mode register selects two optional behaviours. The first, upper-half clearing, forces bits 31:16 of the address driven downstream to zero. The second, alias folding, treats any address whose bits 9:8 are non-zero as an alias of the legacy expansion range and clears bits 15:10 before the window comparison.

Window matching looks only at address bits 15:4, so host addresses above 64 Kbytes always decode into the low range. The claim decision and the downstream address value are registered and appear one clock after the request. In the other direction, a downstream I/O request whose address lies above 64 Kbytes is flagged for rejection one clock later.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the mode word reads 0x00000006 (cfg_sel=0), and both window words read 0 (cfg_sel=1 for window 0, cfg_sel=2 for window 1). cfg_sel=3 reads 0.
- R2: In the mode word only bit 2 (upper-half clear) and bit 1 (alias fold) are writable. All other bits read 0 whatever is written.
- R3: When the upper-half clear is set, fwd_ad is {16'h0, addr[15:0]} of the request. When it is clear, fwd_ad equals the full request address.
- R4: With alias fold clear, the compare key is addr[15:4], whatever addr[9:8] holds.
- R5: With alias fold set and addr[9:8]=00, the compare key is addr[15:4] unchanged.
- R6: With alias fold set and addr[9:8] non-zero, addr[15:10] is cleared before comparison, so the key is {6'b0, addr[9:4]}.
- R7: Address bits 31:16 never influence fwd_claim.
- R8: A window word holds base in bits 11:0, limit in bits 23:12 and enable in bit 31. A window hits when it is enabled and base <= key <= limit, both bounds inclusive. fwd_claim is the OR of both windows' hits.
- R9: fwd_claim and fwd_ad update on the clock edge that samples host_io_valid. When host_io_valid was low they are 0.
- R10: dn_reject is 1 one clock after dn_io_valid with dn_io_addr[31:16] non-zero, and 0 otherwise.
- R11: Window word bits 30:24 read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the selected register |
| cfg_sel | input | 2 | Register select: 0 mode, 1 window 0, 2 window 1 |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_data | output | 32 | Read data of the selected register |
| host_io_valid | input | 1 | Host I/O request present |
| host_io_addr | input | 32 | Host I/O address |
| dn_io_valid | input | 1 | Downstream I/O request present |
| dn_io_addr | input | 32 | Downstream I/O address |
| fwd_claim | output | 1 | Registered claim/forward decision |
| fwd_ad | output | 32 | Registered address value to drive downstream |
| dn_reject | output | 1 | Registered reject for downstream requests above 64 Kbytes |

## Verification
The hardest case to reach is an address that hits a window only through alias folding and misses when folding is off. The stimulus sets up windows in the folded range 0x300..0x3FF. It then sends addresses such as 0x8300 and 0x0002_8310 with both fold settings, and in the same cycle rewrites the mode word, so that the registered decision has to use the mode value from before the write. Window boundaries are probed one key below the base, at the base, at the limit and one key above the limit. Random requests and writes then run against the cycle model.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
    localparam int KEY_W = 12;

    typedef struct packed {
        logic             en;
        logic [KEY_W-1:0] limit;
        logic [KEY_W-1:0] base;
    } io_range_t;

    typedef struct packed {
        logic mask_en;
        logic alias_en;
    } dec_mode_t;

    localparam dec_mode_t MODE_RST = '{mask_en: 1'b1, alias_en: 1'b1};
endpackage

// File: rtl/io_dec_regs.sv
module io_dec_regs
    import io_dec_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter int SEL_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           sel,
    input  logic [31:0]                wdata,
    output dec_mode_t                  mode,
    output io_range_t [NUM_RANGES-1:0] ranges,
    output logic [31:0]                rd_data
);
    typedef struct packed {
        dec_mode_t                  mode;
        io_range_t [NUM_RANGES-1:0] rng;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        if (wr_en) begin
            if (sel == '0) begin
                st_d.mode.mask_en  = wdata[2];
                st_d.mode.alias_en = wdata[1];
            end
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (int'(sel) == i + 1) begin
                    st_d.rng[i].en    = wdata[31];
                    st_d.rng[i].limit = wdata[2*KEY_W-1:KEY_W];
                    st_d.rng[i].base  = wdata[KEY_W-1:0];
                end
            end
        end
        if (sel == '0) begin
            rd_data[2] = st_q.mode.mask_en;
            rd_data[1] = st_q.mode.alias_en;
        end
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (int'(sel) == i + 1) begin
                rd_data[31]              = st_q.rng[i].en;
                rd_data[2*KEY_W-1:KEY_W] = st_q.rng[i].limit;
                rd_data[KEY_W-1:0]       = st_q.rng[i].base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RST;
            st_q.rng  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode   = st_q.mode;
    assign ranges = st_q.rng;
endmodule

// File: rtl/io_dec_fold.sv
module io_dec_fold
    import io_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  dec_mode_t         mode,
    output logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] ad_out
);
    localparam int LOW_W  = 16;
    localparam int FOLD_W = 6;

    always_comb begin
        key = addr[LOW_W-1:4];
        if (mode.alias_en && (addr[9:8] != 2'b00)) begin
            key[KEY_W-1:KEY_W-FOLD_W] = '0;
        end
        ad_out = addr;
        if (mode.mask_en) begin
            ad_out[ADDR_W-1:LOW_W] = '0;
        end
    end
endmodule

// File: rtl/io_range_cmp.sv
module io_range_cmp
    import io_dec_pkg::*;
#(
    parameter int NUM_RANGES = 2
) (
    input  logic [KEY_W-1:0]           key,
    input  io_range_t [NUM_RANGES-1:0] ranges,
    output logic [NUM_RANGES-1:0]      hit
);
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        assign hit[g] = ranges[g].en
                      && (key >= ranges[g].base)
                      && (key <= ranges[g].limit);
    end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import io_dec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rd_data,
    input  logic              host_io_valid,
    input  logic [ADDR_W-1:0] host_io_addr,
    input  logic              dn_io_valid,
    input  logic [ADDR_W-1:0] dn_io_addr,
    output logic              fwd_claim,
    output logic [ADDR_W-1:0] fwd_ad,
    output logic              dn_reject
);
    localparam int LOW_W = 16;

    typedef struct packed {
        logic              claim;
        logic [ADDR_W-1:0] ad;
        logic              reject;
    } out_state_t;

    dec_mode_t                  mode_w;
    io_range_t [NUM_RANGES-1:0] ranges_w;
    logic [KEY_W-1:0]           key_w;
    logic [ADDR_W-1:0]          ad_w;
    logic [NUM_RANGES-1:0]      hit_w;
    out_state_t                 out_d, out_q;

    io_dec_regs #(.NUM_RANGES(NUM_RANGES), .SEL_W(2)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .mode    (mode_w),
        .ranges  (ranges_w),
        .rd_data (cfg_rd_data)
    );

    io_dec_fold #(.ADDR_W(ADDR_W)) u_fold (
        .addr   (host_io_addr),
        .mode   (mode_w),
        .key    (key_w),
        .ad_out (ad_w)
    );

    io_range_cmp #(.NUM_RANGES(NUM_RANGES)) u_cmp (
        .key    (key_w),
        .ranges (ranges_w),
        .hit    (hit_w)
    );

    always_comb begin
        out_d        = '0;
        out_d.reject = dn_io_valid && (dn_io_addr[ADDR_W-1:LOW_W] != '0);
        if (host_io_valid) begin
            out_d.claim = |hit_w;
            out_d.ad    = ad_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fwd_claim = out_q.claim;
    assign fwd_ad    = out_q.ad;
    assign dn_reject = out_q.reject;
endmodule

// File: rtl/io_dec_chk.sv
module io_dec_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_io_valid,
    input logic [ADDR_W-1:0] host_io_addr,
    input logic              dn_io_valid,
    input logic [ADDR_W-1:0] dn_io_addr,
    input logic [1:0]        cfg_sel,
    input logic [31:0]       cfg_rd_data,
    input logic              fwd_claim,
    input logic [ADDR_W-1:0] fwd_ad,
    input logic              dn_reject,
    input logic              mask_en
);
    // R3
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_io_valid && mask_en |=> fwd_ad[ADDR_W-1:16] == '0);

    // R3
    low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_io_valid |=> fwd_ad[15:0] == $past(host_io_addr[15:0]));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_io_valid |=> !fwd_claim && fwd_ad == '0);

    // R10
    reject_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_io_valid && (dn_io_addr[ADDR_W-1:16] != '0) |=> dn_reject);

    // R10
    reject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_io_valid && (dn_io_addr[ADDR_W-1:16] != '0)) |=> !dn_reject);

    // R2
    mode_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel == 2'd0 |-> cfg_rd_data[31:3] == '0 && !cfg_rd_data[0]);

    // R11
    win_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel != 2'd0 |-> cfg_rd_data[30:24] == '0);
endmodule

bind io_window_decoder io_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_io_valid (host_io_valid),
    .host_io_addr  (host_io_addr),
    .dn_io_valid   (dn_io_valid),
    .dn_io_addr    (dn_io_addr),
    .cfg_sel       (cfg_sel),
    .cfg_rd_data   (cfg_rd_data),
    .fwd_claim     (fwd_claim),
    .fwd_ad        (fwd_ad),
    .dn_reject     (dn_reject),
    .mask_en       (mode_w.mask_en)
);

// File: tb/test_io_window_decoder.sv
`timescale 1ns/1ps
module test_io_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rd_data;
    logic        host_io_valid = 1'b0;
    logic [31:0] host_io_addr = '0;
    logic        dn_io_valid = 1'b0;
    logic [31:0] dn_io_addr = '0;
    logic        fwd_claim;
    logic [31:0] fwd_ad;
    logic        dn_reject;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    bit          m_mask  = 1;
    bit          m_alias = 1;
    logic [31:0] m_win [2];

    always #2 clk = ~clk;

    io_window_decoder i_io_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rd_data(cfg_rd_data),
        .host_io_valid(host_io_valid), .host_io_addr(host_io_addr),
        .dn_io_valid(dn_io_valid), .dn_io_addr(dn_io_addr),
        .fwd_claim(fwd_claim), .fwd_ad(fwd_ad), .dn_reject(dn_reject)
    );

    function automatic logic [31:0] model_read(input logic [1:0] s);
        if (s == 2'd0) return {29'd0, m_mask, m_alias, 1'b0};
        if (s == 2'd1) return m_win[0];
        if (s == 2'd2) return m_win[1];
        return 32'd0;
    endfunction

    function automatic bit model_claim(input logic [31:0] a);
        int key = (a >> 4) & 'hfff;
        bit hit = 0;
        if (m_alias && (((a >> 8) & 3) != 0)) key = key & 'h3f;
        foreach (m_win[i]) begin
            int base  = m_win[i] & 'hfff;
            int limit = (m_win[i] >> 12) & 'hfff;
            if (m_win[i][31] && key >= base && key <= limit) hit = 1;
        end
        return hit;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag,
                        input bit hv, input logic [31:0] ha,
                        input bit dv, input logic [31:0] da,
                        input bit we, input logic [1:0] sel, input logic [31:0] wd);
        bit          e_claim, e_rej;
        logic [31:0] e_ad;
        @(negedge clk);
        host_io_valid = hv; host_io_addr = ha;
        dn_io_valid = dv;   dn_io_addr = da;
        cfg_wr_en = we;     cfg_sel = sel; cfg_wdata = wd;
        @(posedge clk);
        e_claim = hv && model_claim(ha);
        e_ad    = hv ? (m_mask ? {16'd0, ha[15:0]} : ha) : 32'd0;
        e_rej   = dv && (da[31:16] != 0);
        if (we) begin
            if (sel == 2'd0) begin m_mask = wd[2]; m_alias = wd[1]; end
            else if (sel != 2'd3) m_win[sel-1] = {wd[31], 7'd0, wd[23:0]};
        end
        #1;
        check(tag, "claim",  {31'd0, fwd_claim}, {31'd0, e_claim});
        check(tag, "ad",     fwd_ad, e_ad);
        check(tag, "reject", {31'd0, dn_reject}, {31'd0, e_rej});
        check(tag, "rd",     cfg_rd_data, model_read(sel));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        m_win[0] = '0; m_win[1] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "claim", {31'd0, fwd_claim}, 32'd0);
        check("R1", "mode",  cfg_rd_data, 32'h6);
        @(negedge clk); rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 2'd1, 0);
        step("R1", 0, 0, 0, 0, 0, 2'd2, 0);
        step("R1", 0, 0, 0, 0, 0, 2'd3, 0);
        // R2 reserved mode bits
        step("R2", 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        step("R2", 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFF9);
        step("R2", 0, 0, 0, 0, 1, 2'd0, 32'h0000_0006);
        // R11 window reserved bits, then program windows (R8)
        step("R11", 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        step("R8", 0, 0, 0, 0, 1, 2'd1, 32'h8003_F030);
        step("R8", 0, 0, 0, 0, 1, 2'd2, 32'h801F_F100);
        // R5 alias on, bits 9:8 zero
        step("R5", 1, 32'h0000_1050, 0, 0, 0, 2'd0, 0);
        step("R5", 1, 32'h0000_4000, 0, 0, 0, 2'd0, 0);
        // R6 folding
        step("R6", 1, 32'h0000_8300, 0, 0, 0, 2'd0, 0);
        step("R6", 1, 32'h0000_C3F0, 0, 0, 0, 2'd0, 0);
        // R7 upper bits ignored, R3 mask on
        step("R7", 1, 32'h0002_8310, 0, 0, 0, 2'd0, 0);
        step("R3", 1, 32'hABCD_1234, 0, 0, 0, 2'd0, 0);
        // R8 boundaries
        step("R8", 1, 32'h0000_02F0, 0, 0, 0, 2'd0, 0);
        step("R8", 1, 32'h0000_0300, 0, 0, 0, 2'd0, 0);
        step("R8", 1, 32'h0000_03FF, 0, 0, 0, 2'd0, 0);
        step("R8", 1, 32'h0000_2000, 0, 0, 0, 2'd0, 0);
        step("R8", 1, 32'h0000_1FFF, 0, 0, 0, 2'd0, 0);
        // R4 alias off, written in the same cycle as a folded request
        step("R4", 1, 32'h0000_8300, 0, 0, 1, 2'd0, 32'h0000_0000);
        step("R4", 1, 32'h0000_8300, 0, 0, 0, 2'd0, 0);
        step("R4", 1, 32'h0000_1300, 0, 0, 0, 2'd0, 0);
        step("R3", 1, 32'h0002_1050, 0, 0, 0, 2'd0, 0);
        step("R7", 1, 32'hFFFF_0350, 0, 0, 0, 2'd0, 0);
        // R8 disabled window
        step("R8", 0, 0, 0, 0, 1, 2'd1, 32'h0003_F030);
        step("R8", 1, 32'h0000_0330, 0, 0, 0, 2'd1, 0);
        // R10 reject
        step("R10", 0, 0, 1, 32'h0001_0000, 0, 2'd0, 0);
        step("R10", 0, 0, 1, 32'h0000_FFFF, 0, 2'd0, 0);
        step("R10", 0, 0, 0, 32'h8000_0000, 0, 2'd0, 0);
        // R9 idle after traffic
        step("R9", 1, 32'h0000_1100, 0, 0, 0, 2'd0, 0);
        step("R9", 0, 32'h0000_1100, 0, 0, 0, 2'd0, 0);
        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a = $urandom;
            logic [31:0] w = $urandom;
            if (n % 3 == 0) a[31:16] = 0;
            if (n % 5 == 0) a[15:12] = 0;
            step("R8", ($urandom % 4) != 0, a, $urandom % 2, $urandom,
                 ($urandom % 8) == 0, 2'($urandom), w);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule